// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire serial audio stream (bit clock, frame clock, data) into parallel left and right sample words. It is a pure slave: the external bit clock is the block's own clock, and the frame clock and data line are sampled on its rising edge. One capture engine serves three alignments: the I2S format, a left-aligned format and a right-aligned format. A small mode input selects the alignment and the sample width.

Each channel half-frame is taken to be 32 bit clocks long. The block finds the data window inside each half-frame from the format and the width. It packs the received bits MSB-first into a 24-bit word and raises a one-cycle strobe once a left word and the right word that follows it are both complete.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0 and both `out_left` and `out_right` are zero.
- R2: `lrck` and `sdata` are sampled only on the rising edge of `clk`, which is the bit clock. A frame edge is a sampled `lrck` value that differs from the previous sample, and that sample is slot 0 of the new half-frame.
- R3: With `fmt` = 2'b01 (left-aligned), the sample MSB is the data bit taken in slot 0.
- R4: With `fmt` = 2'b00 (I2S) or 2'b11 (treated as I2S), the sample MSB is taken in slot 1, one bit clock after the frame edge.
- R5: With `fmt` = 2'b10 (right-aligned), the MSB is taken in slot 32 minus the width: slot 8 for 24 bits, 12 for 20, 14 for 18 and 16 for 16. The LSB then lands in slot 31.
- R6: `wsel` selects the width: 2'b00 gives 16 bits, 2'b01 gives 18, 2'b10 gives 20 and 2'b11 gives 24. Words are MSB-aligned at bit 23 of the output, and the unused low bits are zero.
- R7: In I2S mode, `lrck` low marks the left half-frame. In both aligned modes, `lrck` high marks the left half-frame.
- R8: `out_valid` pulses for exactly one cycle per frame, on the cycle after the frame edge that closes the right half. The output words change only together with that pulse.
- R9: Data bits taken in slots outside the configured window do not affect the output words.
- R10: After reset, no strobe is issued until a complete left half-frame, with an `lrck` edge both before and after it, has been followed by a complete right half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame (word) clock from the link |
| sdata | input | 1 | Serial data from the link |
| fmt | input | 2 | Alignment: 00 I2S, 01 left-aligned, 10 right-aligned, 11 as I2S |
| wsel | input | 2 | Width: 00=16, 01=18, 10=20, 11=24 bits |
| out_valid | output | 1 | One-cycle strobe: a new left/right pair is on the outputs |
| out_left | output | 24 | Left sample, MSB at bit 23 |
| out_right | output | 24 | Right sample, MSB at bit 23 |

## Verification
The hardest case to reach from the ports is alignment after reset. The first `lrck` edge only establishes timing, and a half-frame that started before the first edge must never be reported. The stimulus covers this by starting with a dummy half-frame, and also by starting a stream directly on a left half. In the second case the bench expects the first frame to be dropped and only the second one to be reported. Bits outside the window are driven with random values in every run, so any leak into the capture window shows up as a miscompare.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_LEFT  = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_ALT   = 2'b11
  } fmt_e;

  // Number of data bits selected by the width code.
  function automatic int unsigned width_bits(input logic [1:0] wsel);
    case (wsel)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

  // Slot (counted from the frame edge) that carries the MSB.
  function automatic int unsigned first_slot(input logic [1:0] fmt,
                                             input logic [1:0] wsel,
                                             input int unsigned slots);
    case (fmt_e'(fmt))
      FMT_LEFT:  return 0;
      FMT_RIGHT: return slots - width_bits(wsel);
      default:   return 1;
    endcase
  endfunction

  // lrck level that marks the left half-frame.
  function automatic logic left_level(input logic [1:0] fmt);
    return (fmt == FMT_LEFT) || (fmt == FMT_RIGHT);
  endfunction

endpackage

// File: rtl/serial_audio_frame_track.sv
module serial_audio_frame_track #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lrck,
  input  logic             left_lvl,
  output logic             frame_edge,
  output logic [CNT_W-1:0] slot_idx,
  output logic             cur_left,
  output logic             prev_left,
  output logic             synced
);
  localparam logic [CNT_W-1:0] SLOT_MAX = {CNT_W{1'b1}};

  logic             primed_q;
  logic             lrck_q;
  logic [CNT_W-1:0] slot_q;
  logic             left_q;
  logic             sync_q;

  always_comb begin
    frame_edge = primed_q && (lrck != lrck_q);
    if (frame_edge)
      slot_idx = '0;
    else if (slot_q == SLOT_MAX)
      slot_idx = slot_q;
    else
      slot_idx = slot_q + 1'b1;
    cur_left  = frame_edge ? (lrck == left_lvl) : left_q;
    prev_left = left_q;
    synced    = sync_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      lrck_q   <= 1'b0;
      slot_q   <= SLOT_MAX;
      left_q   <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      lrck_q   <= lrck;
      slot_q   <= slot_idx;
      left_q   <= cur_left;
      if (frame_edge)
        sync_q <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_audio_bit_capture.sv
module serial_audio_bit_capture #(
  parameter int unsigned OUT_W = 24,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_edge,
  input  logic [CNT_W-1:0] slot_idx,
  input  logic [CNT_W-1:0] start_slot,
  input  logic [CNT_W-1:0] nbits,
  input  logic             sdata,
  output logic [OUT_W-1:0] word
);
  logic [OUT_W-1:0] acc_q;
  logic [OUT_W-1:0] acc_d;
  logic [CNT_W-1:0] pos;
  logic             in_window;

  always_comb begin
    pos       = slot_idx - start_slot;
    in_window = (slot_idx >= start_slot) && (pos < nbits);
    acc_d     = frame_edge ? '0 : acc_q;
    for (int b = 0; b < OUT_W; b++) begin
      if (in_window && (pos == CNT_W'(OUT_W - 1 - b)))
        acc_d[b] = sdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else
      acc_q <= acc_d;
  end

  // On a frame edge this still holds the half-frame that just closed.
  assign word = acc_q;
endmodule

// File: rtl/serial_audio_pair_out.sv
module serial_audio_pair_out #(
  parameter int unsigned OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_edge,
  input  logic             synced,
  input  logic             prev_left,
  input  logic [OUT_W-1:0] word,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  logic [OUT_W-1:0] left_hold_q;
  logic             have_left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      out_valid   <= 1'b0;
      out_left    <= '0;
      out_right   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (frame_edge && synced) begin
        if (prev_left) begin
          left_hold_q <= word;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          out_left    <= left_hold_q;
          out_right   <= word;
          out_valid   <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int unsigned OUT_W = 24,
  parameter int unsigned SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lrck,
  input  logic             sdata,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wsel,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  import serial_audio_rx_pkg::*;

  localparam int unsigned CNT_W = $clog2(SLOTS) + 2;

  logic             frame_edge;
  logic [CNT_W-1:0] slot_idx;
  logic             cur_left;
  logic             prev_left;
  logic             synced;
  logic [CNT_W-1:0] start_slot;
  logic [CNT_W-1:0] nbits;
  logic             left_lvl;
  logic [OUT_W-1:0] word;

  always_comb begin
    start_slot = CNT_W'(first_slot(fmt, wsel, SLOTS));
    nbits      = CNT_W'(width_bits(wsel));
    left_lvl   = left_level(fmt);
  end

  serial_audio_frame_track #(.CNT_W(CNT_W)) track_i (
    .clk(clk), .rst(rst), .lrck(lrck), .left_lvl(left_lvl),
    .frame_edge(frame_edge), .slot_idx(slot_idx), .cur_left(cur_left),
    .prev_left(prev_left), .synced(synced)
  );

  serial_audio_bit_capture #(.OUT_W(OUT_W), .CNT_W(CNT_W)) cap_i (
    .clk(clk), .rst(rst), .frame_edge(frame_edge), .slot_idx(slot_idx),
    .start_slot(start_slot), .nbits(nbits), .sdata(sdata), .word(word)
  );

  serial_audio_pair_out #(.OUT_W(OUT_W)) pair_i (
    .clk(clk), .rst(rst), .frame_edge(frame_edge), .synced(synced),
    .prev_left(prev_left), .word(word), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );
endmodule

// File: rtl/serial_audio_rx_checker.sv
module serial_audio_rx_checker #(
  parameter int unsigned OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             lrck,
  input logic [1:0]       wsel,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_left,
  input logic [OUT_W-1:0] out_right
);
  logic             primed_q;
  logic             lrck_q;
  logic [1:0]       edges_q;
  logic             past_ok_q;
  logic [OUT_W-1:0] low_mask;

  always_comb begin
    low_mask = '0;
    for (int b = 0; b < OUT_W; b++)
      if (b < (OUT_W - serial_audio_rx_pkg::width_bits(wsel)))
        low_mask[b] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q  <= 1'b0;
      lrck_q    <= 1'b0;
      edges_q   <= '0;
      past_ok_q <= 1'b0;
    end else begin
      primed_q  <= 1'b1;
      lrck_q    <= lrck;
      past_ok_q <= 1'b1;
      if (primed_q && (lrck != lrck_q) && edges_q != 2'd3)
        edges_q <= edges_q + 2'd1;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_left == '0 && out_right == '0));

  // R8
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8
  p_hold_words_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

  // R6
  p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((out_left & low_mask) == '0) && ((out_right & low_mask) == '0)));

  // R10
  p_no_early_valid_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (edges_q == 2'd3));
endmodule

bind serial_audio_rx serial_audio_rx_checker #(.OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .lrck(lrck), .wsel(wsel),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [1:0]  wsel = 2'b11;
  logic        out_valid;
  logic [23:0] out_left;
  logic [23:0] out_right;

  int checks = 0;
  int fails = 0;
  int valids_seen = 0;
  logic [23:0] exp_l_q[$];
  logic [23:0] exp_r_q[$];
  string cur_req = "R3";
  bit prev_valid = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst(rst), .lrck(lrck), .sdata(sdata), .fmt(fmt),
    .wsel(wsel), .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: compares every strobe against the expected pair (R7, R8, R9).
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        valids_seen++;
        check(!prev_valid, "R8", "strobe longer than one cycle", 48'(out_valid), 48'd0);
        if (exp_l_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected strobe", {out_left, out_right}, 48'd0);
        end else begin
          logic [23:0] el, er;
          el = exp_l_q.pop_front();
          er = exp_r_q.pop_front();
          check({out_left, out_right} == {el, er}, cur_req, "left/right pair (R7)",
                {out_left, out_right}, {el, er});
        end
      end
      prev_valid = out_valid;
    end
  end

  function automatic int wbits(input logic [1:0] w);
    case (w)
      2'b00: return 16;
      2'b01: return 18;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int msb_slot(input logic [1:0] f, input logic [1:0] w);
    if (f == 2'b01) return 0;
    if (f == 2'b10) return 32 - wbits(w);
    return 1;
  endfunction

  function automatic logic [23:0] trim(input logic [23:0] v, input logic [1:0] w);
    logic [23:0] m;
    m = '1;
    m = m << (24 - wbits(w));
    return v & m;
  endfunction

  task automatic drive_half(input logic lvl, input logic [23:0] val);
    int st, n;
    st = msb_slot(fmt, wsel);
    n  = wbits(wsel);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      lrck = lvl;
      if (s >= st && s < st + n) sdata = val[23 - (s - st)];
      else sdata = 1'($urandom);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    prev_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_stream(input logic [1:0] f, input logic [1:0] w, input int nfr,
                            input bit lead_in, input string req);
    logic ll;
    int base;
    fmt = f; wsel = w; cur_req = req;
    ll = (f == 2'b01 || f == 2'b10);
    lrck = ll;
    do_reset();
    base = valids_seen;
    if (lead_in) drive_half(~ll, 24'h5A5A5A);
    for (int i = 0; i < nfr; i++) begin
      logic [23:0] lv, rv;
      lv = 24'($urandom); rv = 24'($urandom);
      if (i == 0) begin lv = 24'h800001; rv = 24'h7FFFFF; end
      if (lead_in || i > 0) begin
        exp_l_q.push_back(trim(lv, w));
        exp_r_q.push_back(trim(rv, w));
      end
      drive_half(ll, lv);
      drive_half(~ll, rv);
    end
    drive_half(ll, 24'h000000);
    repeat (2) @(negedge clk);
    check(exp_l_q.size() == 0, req, "missing strobes", 48'(exp_l_q.size()), 48'd0);
    check(valids_seen - base == (lead_in ? nfr : nfr - 1), req, "strobe count",
          48'(valids_seen - base), 48'(lead_in ? nfr : nfr - 1));
    exp_l_q.delete(); exp_r_q.delete();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && out_left == 0 && out_right == 0, "R1", "reset outputs",
          {out_left, out_right}, 48'd0);
    rst = 1'b0;
  endtask

  task automatic t_left_aligned();  run_stream(2'b01, 2'b11, 4, 1'b1, "R3"); endtask
  task automatic t_i2s();           run_stream(2'b00, 2'b11, 4, 1'b1, "R4");
                                    run_stream(2'b11, 2'b00, 3, 1'b1, "R4"); endtask
  task automatic t_right_widths();
    for (int w = 0; w < 4; w++) run_stream(2'b10, 2'(w), 3, 1'b1, "R5");
  endtask
  task automatic t_widths();
    for (int w = 0; w < 3; w++) run_stream(2'b01, 2'(w), 3, 1'b1, "R6");
    run_stream(2'b00, 2'b01, 3, 1'b1, "R9");
  endtask
  task automatic t_no_lead_in();    run_stream(2'b00, 2'b10, 3, 1'b0, "R10");
                                    run_stream(2'b10, 2'b11, 3, 1'b0, "R2"); endtask

  initial begin
    fork
      begin
        t_reset();
        t_left_aligned();
        t_i2s();
        t_right_widths();
        t_widths();
        t_no_lead_in();
        done = 1'b1;
      end
      begin
        repeat (150000) @(negedge clk);
        if (!done) check(1'b0, "R8", "watchdog expired", 48'd0, 48'd1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule